// File: doc/BRIEF.md
# Host Interrupt Aggregator with Mask and Polarity Control

This block collects single-cycle event pulses from the wireless MAC's internal engines and holds each one in a sticky status flag until the host clears it. A per-bit mask register keeps selected flags from reaching the host. A single registered interrupt line goes to the host. A configuration register controls whether the line is enabled and whether it is active high or active low.

The host reaches the block over a small single-request register bus. The mask is a read-write register. Two write-only aliases beside it set or clear individual mask bits without a read-modify-write. The status flags have two read views: one leaves the flags unchanged, and the other clears all of them once it has returned them. A write-one acknowledge register clears individual flags. When an event arrives in the same cycle as a clear of its flag, the event wins.

The bus side is a two-state machine. In `ST_IDLE` the block accepts a request (`bus_req` high). It performs the write, or captures the read data, at that edge and moves to `ST_RESP`. In `ST_RESP` it raises `bus_ack` with `bus_rdata` valid for one cycle, ignores `bus_req`, and always returns to `ST_IDLE` on the next edge.

Top module: `host_irq_ctrl`

## Requirements
- R1: Status and mask bits exist only at positions 0-10, 14, 16 and 17: Rx buffer 0, Tx data, Tx transfer, Rx buffer 1, Rx transfer, two mailbox events, wake-on-host, two trace events, command complete, init complete, coexistence sense on and off. Every other bit always reads as zero, and an event on a reserved position sets nothing.
- R2: After reset the mask reads 0x0001, both status views read 0, the configuration reads 0, and `irq_o` is low.
- R3: A write to address 1 (mask set, write-only) ORs the written ones into the mask. Written zeros leave mask bits unchanged.
- R4: A write to address 2 (mask clear, write-only) clears the mask bits where ones are written. Written zeros leave mask bits unchanged.
- R5: A read of address 3 returns the status flags and leaves them unchanged.
- R6: A read of address 4 returns the status flags and clears all of them at the same edge.
- R7: A write to address 5 clears the status flags where ones are written. Both status views show the change, and written zeros have no effect.
- R8: An event that arrives in the same cycle as a clear of its flag (address-4 read or address-5 write) leaves the flag set.
- R9: The host line is pending when any status bit is 1 while its mask bit is 0. `irq_o` follows the pending state one clock after the status or mask change.
- R10: Configuration register, address 6: bit 5 enables the line and bit 7 selects active low. When disabled, `irq_o` rests at its inactive level, which is low for active high and high for active low. When enabled, `irq_o` takes the active level while pending and the inactive level otherwise. Only bits 5 and 7 are kept and read back.
- R11: Address 0 reads back the current mask, and a write to it loads the mask. Addresses 1, 2 and 5 read as zero.
- R12: A request is taken only in `ST_IDLE`. `bus_ack` and `bus_rdata` are valid in the following cycle, and a request raised during `ST_RESP` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | N_SRC | Single-cycle event pulses, one per status position |
| bus_req | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_ack | output | 1 | Access complete, one cycle |
| bus_rdata | output | DATA_W | Read data, valid with bus_ack |
| irq_o | output | 1 | Registered host interrupt line |

## Verification
The bench builds the block with its default parameters: 18 source positions, a 32-bit bus, enable at bit 5 and active low at bit 7. These positions are few enough to pulse every event position one at a time, including the reserved ones, and to set and then clear every mask bit across the full 32-bit write word. With this configuration the bench can also reach every combination of enable and polarity against a pending line. It also drives events in the same cycle as both kinds of clear.

// File: rtl/hic_pkg.sv
package hic_pkg;
    localparam int HIC_AW = 3;

    typedef enum logic [HIC_AW-1:0] {
        A_MASK     = 3'd0,
        A_MASK_SET = 3'd1,
        A_MASK_CLR = 3'd2,
        A_STAT_ND  = 3'd3,
        A_STAT_COR = 3'd4,
        A_ACK      = 3'd5,
        A_CFG      = 3'd6
    } hic_addr_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } hic_state_e;
endpackage

// File: rtl/hic_status.sv
module hic_status #(
    parameter int          N_SRC = 18,
    parameter logic [N_SRC-1:0] VALID = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] ev_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] stat_o
);
    logic [N_SRC-1:0] stat_q;

    // Arriving events override a clear of the same bit in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= ((stat_q & ~clr_i) | ev_i) & VALID;
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/hic_mask.sv
module hic_mask #(
    parameter int          N_SRC = 18,
    parameter logic [N_SRC-1:0] VALID = '1,
    parameter logic [N_SRC-1:0] RST   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             set_i,
    input  logic             clr_i,
    input  logic [N_SRC-1:0] wdata_i,
    output logic [N_SRC-1:0] mask_o
);
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] mask_d;

    always_comb begin
        mask_d = mask_q;
        if (load_i)     mask_d = wdata_i;
        else if (set_i) mask_d = mask_q | wdata_i;
        else if (clr_i) mask_d = mask_q & ~wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= RST & VALID;
        else        mask_q <= mask_d & VALID;
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/hic_bus_fsm.sv
module hic_bus_fsm
    import hic_pkg::*;
#(
    parameter int N_SRC   = 18,
    parameter int DATA_W  = 32,
    parameter int EN_BIT  = 5,
    parameter int LOW_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [HIC_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_SRC-1:0]  stat_i,
    input  logic [N_SRC-1:0]  mask_i,
    output logic              mask_load,
    output logic              mask_set,
    output logic              mask_clr,
    output logic [N_SRC-1:0]  stat_clr,
    output logic              cfg_en,
    output logic              cfg_low,
    output logic              idle_o
);
    hic_state_e state_q, state_d;
    logic        take;
    logic        take_wr;
    logic        take_rd;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    assign take    = (state_q == ST_IDLE) && bus_req;
    assign take_wr = take && bus_wr;
    assign take_rd = take && !bus_wr;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (bus_req) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign mask_load = take_wr && (bus_addr == A_MASK);
    assign mask_set  = take_wr && (bus_addr == A_MASK_SET);
    assign mask_clr  = take_wr && (bus_addr == A_MASK_CLR);

    always_comb begin
        stat_clr = '0;
        if (take_wr && (bus_addr == A_ACK))      stat_clr = bus_wdata[N_SRC-1:0];
        if (take_rd && (bus_addr == A_STAT_COR)) stat_clr = '1;
    end

    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            A_MASK:               rd_mux = DATA_W'(mask_i);
            A_STAT_ND, A_STAT_COR: rd_mux = DATA_W'(stat_i);
            A_CFG: begin
                rd_mux[EN_BIT]  = cfg_en;
                rd_mux[LOW_BIT] = cfg_low;
            end
            default:              rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            cfg_en  <= 1'b0;
            cfg_low <= 1'b0;
        end else begin
            if (take) rdata_q <= bus_wr ? '0 : rd_mux;
            if (take_wr && (bus_addr == A_CFG)) begin
                cfg_en  <= bus_wdata[EN_BIT];
                cfg_low <= bus_wdata[LOW_BIT];
            end
        end
    end

    assign bus_ack   = (state_q == ST_RESP);
    assign bus_rdata = bus_ack ? rdata_q : '0;
    assign idle_o    = (state_q == ST_IDLE);
endmodule

// File: rtl/host_irq_ctrl.sv
module host_irq_ctrl
    import hic_pkg::*;
#(
    parameter int N_SRC   = 18,
    parameter int DATA_W  = 32,
    parameter logic [N_SRC-1:0] SRC_VALID = 18'h347FF,
    parameter logic [N_SRC-1:0] MASK_RST  = 18'h00001,
    parameter int EN_BIT  = 5,
    parameter int LOW_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  ev_i,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [HIC_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    logic [N_SRC-1:0] stat_q;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] stat_clr;
    logic             mask_load, mask_set, mask_clr;
    logic             cfg_en, cfg_low, fsm_idle;
    logic             pending;
    logic             irq_q;

    hic_bus_fsm #(
        .N_SRC(N_SRC), .DATA_W(DATA_W), .EN_BIT(EN_BIT), .LOW_BIT(LOW_BIT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .stat_i(stat_q), .mask_i(mask_q),
        .mask_load(mask_load), .mask_set(mask_set), .mask_clr(mask_clr),
        .stat_clr(stat_clr), .cfg_en(cfg_en), .cfg_low(cfg_low),
        .idle_o(fsm_idle)
    );

    hic_status #(.N_SRC(N_SRC), .VALID(SRC_VALID)) u_stat (
        .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .clr_i(stat_clr), .stat_o(stat_q)
    );

    hic_mask #(.N_SRC(N_SRC), .VALID(SRC_VALID), .RST(MASK_RST)) u_mask (
        .clk(clk), .rst_n(rst_n), .load_i(mask_load), .set_i(mask_set),
        .clr_i(mask_clr), .wdata_i(bus_wdata[N_SRC-1:0]), .mask_o(mask_q)
    );

    assign pending = cfg_en && (|(stat_q & ~mask_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= pending ^ cfg_low;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/hic_checker.sv
module hic_checker
    import hic_pkg::*;
#(
    parameter int N_SRC  = 18,
    parameter int DATA_W = 32,
    parameter logic [N_SRC-1:0] SRC_VALID = 18'h347FF
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  ev_i,
    input logic              bus_req,
    input logic              bus_wr,
    input logic [HIC_AW-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ack,
    input logic              irq_o,
    input logic [N_SRC-1:0]  stat_q,
    input logic [N_SRC-1:0]  mask_q,
    input logic              cfg_en,
    input logic              cfg_low,
    input logic              fsm_idle
);
    logic taken;
    assign taken = fsm_idle && bus_req;

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q | mask_q) & ~SRC_VALID) == '0);

    assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && bus_wr && bus_addr == A_MASK_SET)
        |=> mask_q == ($past(mask_q) | ($past(bus_wdata[N_SRC-1:0]) & SRC_VALID)));

    assert_mask_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && bus_wr && bus_addr == A_MASK_CLR)
        |=> mask_q == ($past(mask_q) & ~$past(bus_wdata[N_SRC-1:0])));

    assert_nd_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !bus_wr && bus_addr == A_STAT_ND && ev_i == '0)
        |=> $stable(stat_q));

    assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i != '0) |=> ((stat_q & $past(ev_i & SRC_VALID)) == $past(ev_i & SRC_VALID)));

    assert_idle_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_en) |-> (irq_o == $past(cfg_low)));

    assert_ack_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> bus_ack);

    assert_ack_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);
endmodule

bind host_irq_ctrl hic_checker #(
    .N_SRC(N_SRC), .DATA_W(DATA_W), .SRC_VALID(SRC_VALID)
) chk_i (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .irq_o(irq_o),
    .stat_q(stat_q), .mask_q(mask_q), .cfg_en(cfg_en), .cfg_low(cfg_low),
    .fsm_idle(fsm_idle)
);

// File: tb/host_irq_ctrl_tb_top.sv
module host_irq_ctrl_tb_top;
    localparam int N = 18;
    localparam logic [31:0] VALID = 32'h347FF;
    localparam logic [2:0] AD_MASK = 3'd0, AD_SET = 3'd1, AD_CLR = 3'd2,
                           AD_ND = 3'd3, AD_COR = 3'd4, AD_ACK = 3'd5, AD_CFG = 3'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] ev = '0;
    logic        req = 1'b0, wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        ack;
    logic [31:0] rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;
    logic [31:0] m_mask;
    logic [31:0] rd;

    always #5 clk = ~clk;

    host_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ev_i(ev), .bus_req(req), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_ack(ack), .bus_rdata(rdata),
        .irq_o(irq)
    );

    task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); req = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); req = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); req = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk); d = rdata; req = 1'b0;
    endtask

    task automatic pulse(input logic [N-1:0] v);
        @(negedge clk); ev = v;
        @(negedge clk); ev = '0;
    endtask

    task automatic check_irq(input string r, input logic exp);
        @(negedge clk);
        check(r, {31'b0, irq}, {31'b0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R2 irq in reset", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 irq after reset", {31'b0, irq}, 32'h0);
        check("R12 ack idle", {31'b0, ack}, 32'h0);
        bus_read(AD_MASK, rd); check("R2 mask reset", rd, 32'h1);
        bus_read(AD_ND, rd);   check("R2 status reset", rd, 32'h0);
        bus_read(AD_CFG, rd);  check("R2 cfg reset", rd, 32'h0);

        bus_write(AD_CFG, 32'hFFFF_FFFF);
        bus_read(AD_CFG, rd);  check("R10 cfg keeps bits 5,7", rd, 32'hA0);
        bus_write(AD_CFG, 32'h20);
        bus_write(AD_MASK, 32'hFFFF_FFFF);
        bus_read(AD_MASK, rd); check("R1 R11 mask full", rd, VALID);
        bus_write(AD_MASK, 32'h0);
        bus_read(AD_MASK, rd); check("R11 mask zero", rd, 32'h0);

        // R1 R5 R7 R9: every source position alone
        for (int i = 0; i < N; i++) begin
            pulse(N'(1) << i);
            check_irq("R9 irq per source", VALID[i]);
            bus_read(AD_ND, rd); check("R1 status position", rd, VALID & (32'h1 << i));
            bus_read(AD_ND, rd); check("R5 nondestructive", rd, VALID & (32'h1 << i));
            bus_write(AD_ACK, 32'h1 << i);
            bus_read(AD_ND, rd); check("R7 ack clears", rd, 32'h0);
        end

        // R3 R11: set alias across all bus bits
        m_mask = 32'h0;
        for (int i = 0; i < 32; i++) begin
            bus_write(AD_SET, 32'h1 << i);
            m_mask |= VALID & (32'h1 << i);
            bus_read(AD_MASK, rd); check("R3 mask set", rd, m_mask);
        end
        bus_read(AD_SET, rd); check("R11 set alias reads 0", rd, 32'h0);
        bus_read(AD_CLR, rd); check("R11 clr alias reads 0", rd, 32'h0);
        bus_read(AD_ACK, rd); check("R11 ack reads 0", rd, 32'h0);
        // R4: clear alias, highest first
        for (int i = 31; i >= 0; i--) begin
            bus_write(AD_CLR, 32'h1 << i);
            m_mask &= ~(32'h1 << i);
            bus_read(AD_MASK, rd); check("R4 mask clear", rd, m_mask);
        end

        // R9 masking, R10 polarity and enable
        pulse(N'(1) << 3);
        check_irq("R9 pending", 1'b1);
        bus_write(AD_SET, 32'h8);
        check_irq("R9 masked", 1'b0);
        bus_write(AD_CLR, 32'h8);
        check_irq("R9 unmasked", 1'b1);
        bus_write(AD_CFG, 32'hA0);
        check_irq("R10 active low asserted", 1'b0);
        bus_write(AD_SET, 32'h8);
        check_irq("R10 active low idle", 1'b1);
        bus_write(AD_CLR, 32'h8);
        bus_write(AD_CFG, 32'h80);
        check_irq("R10 disabled low idle", 1'b1);
        bus_write(AD_CFG, 32'h00);
        check_irq("R10 disabled high idle", 1'b0);
        bus_write(AD_CFG, 32'h20);

        // R6 clear on read
        pulse(N'(1) << 10);
        bus_read(AD_COR, rd); check("R6 cor returns", rd, 32'h408);
        bus_read(AD_ND, rd);  check("R6 cor cleared", rd, 32'h0);
        bus_read(AD_COR, rd); check("R6 cor empty", rd, 32'h0);
        check_irq("R9 no pending", 1'b0);

        // R8 event vs acknowledge
        pulse(N'(1) << 1);
        @(negedge clk); req = 1'b1; wr = 1'b1; addr = AD_ACK; wdata = 32'h2; ev = N'(2);
        @(negedge clk); req = 1'b0; wr = 1'b0; ev = '0;
        bus_read(AD_ND, rd); check("R8 event beats ack", rd, 32'h2);
        // R8 event vs clear-on-read
        @(negedge clk); req = 1'b1; wr = 1'b0; addr = AD_COR; ev = N'(32'h10);
        @(negedge clk); rd = rdata; req = 1'b0; ev = '0;
        check("R8 cor data", rd, 32'h2);
        bus_read(AD_ND, rd); check("R8 event beats cor", rd, 32'h10);

        // R12 request during response ignored
        @(negedge clk); req = 1'b1; wr = 1'b1; addr = AD_SET; wdata = 32'h20;
        @(negedge clk);
        check("R12 ack one cycle after", {31'b0, ack}, 32'h1);
        wdata = 32'h40;
        @(negedge clk);
        check("R12 ack drops", {31'b0, ack}, 32'h0);
        req = 1'b0; wr = 1'b0; wdata = '0;
        bus_read(AD_MASK, rd); check("R12 second request ignored", rd, 32'h20);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule